// File: doc/BRIEF.md
# 64-bit Global Timer with Self-Reloading Comparator

This block is a free-running 64-bit up-counter with a 64-bit comparator, reached over a small 32-bit register bus with an address, a write enable, write data and combinational read data. When the comparator is armed and the counter equals the compare value, a sticky event flag is raised one cycle later. A level interrupt output follows that flag, gated by an enable bit.

For periodic ticks, software programs a 32-bit step once and turns on auto-reload. Each match then adds the step to the 64-bit compare value, so the next match falls one step later without any comparator rewrite. Software clears the event by writing one to the status bit. A consistent 64-bit count is read as high word, low word and high word again, retrying when the two high words differ. Reads never have side effects, which is what makes that sequence work.

Register word addresses: 0 count low, 1 count high, 2 control, 3 status, 4 compare low, 5 compare high, 6 step. Other addresses read as zero and ignore writes.

Top module: `glb_timer`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero and `irq` is 0.
- R2: While control bit 0 (run) is 1, the counter increments by exactly one per clock. While run is 0 it holds its value.
- R3: The counter carries from its low word into its high word, and wraps from all ones to zero.
- R4: Writes to count low (address 0) or count high (address 1) load that half only while run is 0. While run is 1 they have no effect.
- R5: When control bit 1 (compare enable) is 1 and the counter equals the compare value, status bit 0 (event flag) is set in the next cycle. With compare enable at 0, no flag is raised.
- R6: The event flag stays set after the counter passes the compare point. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged.
- R7: If a clear of the flag and a new match occur in the same cycle, the flag remains set.
- R8: `irq` is 1 exactly when the event flag is 1 and control bit 2 (interrupt enable) is 1.
- R9: With control bit 3 (auto-reload) at 1, each match adds the step register (address 6) to the 64-bit compare value. With auto-reload at 0, the compare value is unchanged by a match.
- R10: Reading any register, including count low, changes no state; in particular, reading the low word does not alter the high word.
- R11: Control reads back its four enable bits in bits 3..0, with zeros above. Status reads back the flag in bit 0, with zeros above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt: event flag AND interrupt enable |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the very cycle of a fresh match. With a running counter that cycle is a single clock wide. The stimulus instead stops the counter at a value equal to the compare value with compare enable on, so a match is present in every cycle, and then issues the clear; the flag must survive. The full 64-bit wrap is reached by loading all ones minus one while stopped, then releasing run for two cycles.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

    localparam int HALF_W = 32;
    localparam int FULL_W = 2 * HALF_W;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CNT_LO = 3'd0,
        RA_CNT_HI = 3'd1,
        RA_CTRL   = 3'd2,
        RA_STAT   = 3'd3,
        RA_CMP_LO = 3'd4,
        RA_CMP_HI = 3'd5,
        RA_STEP   = 3'd6
    } reg_addr_e;

    // bit 0 run, bit 1 compare enable, bit 2 interrupt enable, bit 3 auto-reload
    typedef struct packed {
        logic auto_en;
        logic irq_en;
        logic cmp_en;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic              lo;
        logic              hi;
        logic [HALF_W-1:0] data;
    } half_wr_t;

    function automatic logic [FULL_W-1:0] merge_half(
        input logic [FULL_W-1:0] cur,
        input half_wr_t          w
    );
        logic [FULL_W-1:0] r;
        r = cur;
        if (w.lo) r[HALF_W-1:0]      = w.data;
        if (w.hi) r[FULL_W-1:HALF_W] = w.data;
        return r;
    endfunction

endpackage

// File: rtl/gtmr_regbank.sv
module gtmr_regbank
    import gtmr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  we,
    input  logic [HALF_W-1:0]     wdata,
    input  logic [FULL_W-1:0]     cnt,
    input  logic [FULL_W-1:0]     cmp,
    input  logic                  flag,
    output logic [HALF_W-1:0]     rdata,
    output ctrl_t                 ctrl,
    output logic [HALF_W-1:0]     step,
    output half_wr_t              cnt_wr,
    output half_wr_t              cmp_wr,
    output logic                  clr_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            step <= '0;
        end else if (we) begin
            if (addr == RA_CTRL) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (addr == RA_STEP) step <= wdata;
        end
    end

    always_comb begin
        cnt_wr.lo   = we && (addr == RA_CNT_LO);
        cnt_wr.hi   = we && (addr == RA_CNT_HI);
        cnt_wr.data = wdata;
        cmp_wr.lo   = we && (addr == RA_CMP_LO);
        cmp_wr.hi   = we && (addr == RA_CMP_HI);
        cmp_wr.data = wdata;
        clr_flag    = we && (addr == RA_STAT) && wdata[0];
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_CNT_LO: rdata = cnt[HALF_W-1:0];
            RA_CNT_HI: rdata = cnt[FULL_W-1:HALF_W];
            RA_CTRL:   rdata = {{(HALF_W-CTRL_W){1'b0}}, ctrl};
            RA_STAT:   rdata = {{(HALF_W-1){1'b0}}, flag};
            RA_CMP_LO: rdata = cmp[HALF_W-1:0];
            RA_CMP_HI: rdata = cmp[FULL_W-1:HALF_W];
            RA_STEP:   rdata = step;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter
    import gtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  half_wr_t          wr,
    output logic [FULL_W-1:0] cnt
);

    // loads are only honoured while stopped; running always wins
    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
        else          cnt <= merge_half(cnt, wr);
    end

endmodule

// File: rtl/gtmr_compare.sv
module gtmr_compare
    import gtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FULL_W-1:0] cnt,
    input  logic              cmp_en,
    input  logic              auto_en,
    input  logic [HALF_W-1:0] step,
    input  half_wr_t          wr,
    input  logic              clr,
    output logic [FULL_W-1:0] cmp,
    output logic              flag
);

    logic hit;
    assign hit = cmp_en && (cnt == cmp);

    // a software write to either half takes precedence over the reload
    always_ff @(posedge clk) begin
        if (rst)                   cmp <= '0;
        else if (wr.lo || wr.hi)   cmp <= merge_half(cmp, wr);
        else if (hit && auto_en)   cmp <= cmp + {{HALF_W{1'b0}}, step};
    end

    // set dominates clear
    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= (flag && !clr) || hit;
    end

endmodule

// File: rtl/glb_timer.sv
module glb_timer
    import gtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    ctrl_t              ctrl_q;
    logic [HALF_W-1:0]  step_q;
    logic [FULL_W-1:0]  cnt_q;
    logic [FULL_W-1:0]  cmp_q;
    logic               flag_q;
    half_wr_t           cnt_wr;
    half_wr_t           cmp_wr;
    logic               clr_flag;

    gtmr_regbank u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .cnt      (cnt_q),
        .cmp      (cmp_q),
        .flag     (flag_q),
        .rdata    (bus_rdata),
        .ctrl     (ctrl_q),
        .step     (step_q),
        .cnt_wr   (cnt_wr),
        .cmp_wr   (cmp_wr),
        .clr_flag (clr_flag)
    );

    gtmr_counter u_cnt (
        .clk (clk),
        .rst (rst),
        .run (ctrl_q.run),
        .wr  (cnt_wr),
        .cnt (cnt_q)
    );

    gtmr_compare u_cmp (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt_q),
        .cmp_en  (ctrl_q.cmp_en),
        .auto_en (ctrl_q.auto_en),
        .step    (step_q),
        .wr      (cmp_wr),
        .clr     (clr_flag),
        .cmp     (cmp_q),
        .flag    (flag_q)
    );

    assign irq = flag_q && ctrl_q.irq_en;

endmodule

// File: rtl/gtmr_checker.sv
module gtmr_checker
    import gtmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic [HALF_W-1:0] wdata,
    input ctrl_t             ctrl,
    input logic [HALF_W-1:0] step,
    input logic [FULL_W-1:0] cnt,
    input logic [FULL_W-1:0] cmp,
    input logic              flag,
    input logic              irq
);

    logic eq;
    logic cnt_w;
    logic cmp_w;
    logic clr_w;
    assign eq    = ctrl.cmp_en && (cnt == cmp);
    assign cnt_w = we && (addr == RA_CNT_LO || addr == RA_CNT_HI);
    assign cmp_w = we && (addr == RA_CMP_LO || addr == RA_CMP_HI);
    assign clr_w = we && (addr == RA_STAT) && wdata[0];

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl.run |=> cnt == $past(cnt) + 64'd1);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !cnt_w) |=> $stable(cnt));

    p_set_r5: assert property (@(posedge clk) disable iff (rst)
        eq |=> flag);

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_w) |=> flag);

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_w && !eq) |=> !flag);

    p_collide_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_w && eq) |=> flag);

    p_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !(flag && ctrl.irq_en) |-> !irq);

    p_fire_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && ctrl.irq_en) |-> irq);

    p_reload_r9: assert property (@(posedge clk) disable iff (rst)
        (eq && ctrl.auto_en && !cmp_w) |=> cmp == $past(cmp) + {32'd0, $past(step)});

    p_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (!(eq && ctrl.auto_en) && !cmp_w) |=> $stable(cmp));

endmodule

bind glb_timer gtmr_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .addr  (bus_addr),
    .we    (bus_we),
    .wdata (bus_wdata),
    .ctrl  (ctrl_q),
    .step  (step_q),
    .cnt   (cnt_q),
    .cmp   (cmp_q),
    .flag  (flag_q),
    .irq   (irq)
);

// File: tb/sim_glb_timer.sv
`timescale 1ns/1ps
module sim_glb_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    glb_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic load_cnt(input logic [31:0] hi, input logic [31:0] lo);
        wr(3'd2, 32'h0);
        wr(3'd0, lo);
        wr(3'd1, hi);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 7; a++) begin
            rd(a[2:0], v);
            chk("R1 reg after reset", v, 32'h0);
        end
        chk("R1 irq after reset", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_count;
        logic [31:0] a, b;
        load_cnt(32'h0, 32'd10);
        wr(3'd2, 32'h1);
        rd(3'd0, a);
        repeat (7) @(negedge clk);
        rd(3'd0, b);
        chk("R2 increments 7 in 7 cycles", b - a, 32'd7);
        wr(3'd2, 32'h0);
        rd(3'd0, a);
        repeat (5) @(negedge clk);
        rd(3'd0, b);
        chk("R2 holds while stopped", b, a);
    endtask

    task automatic t_wrap;
        logic [31:0] lo, hi;
        load_cnt(32'h5, 32'hFFFF_FFFF);
        wr(3'd2, 32'h1);
        @(negedge clk);
        rd(3'd0, lo); rd(3'd1, hi);
        chk("R3 carry low word", lo, 32'h0);
        chk("R3 carry high word", hi, 32'h6);
        load_cnt(32'hFFFF_FFFF, 32'hFFFF_FFFE);
        wr(3'd2, 32'h1);
        repeat (2) @(negedge clk);
        rd(3'd0, lo); rd(3'd1, hi);
        chk("R3 wrap low", lo, 32'h0);
        chk("R3 wrap high", hi, 32'h0);
    endtask

    task automatic t_wr_guard;
        logic [31:0] hi, lo;
        load_cnt(32'h0, 32'h0);
        wr(3'd2, 32'h1);
        wr(3'd1, 32'hABCD);
        wr(3'd0, 32'h8000_0000);
        rd(3'd1, hi); rd(3'd0, lo);
        chk("R4 high write ignored while running", hi, 32'h0);
        chk("R4 low write ignored while running", {31'd0, lo < 32'd20}, 32'h1);
        wr(3'd2, 32'h0);
        wr(3'd1, 32'h77);
        rd(3'd1, hi);
        chk("R4 high write taken while stopped", hi, 32'h77);
    endtask

    task automatic t_match;
        logic [31:0] s, c;
        bit seen = 0;
        load_cnt(32'h0, 32'd100);
        wr(3'd4, 32'd105);
        wr(3'd5, 32'd0);
        wr(3'd3, 32'h1);
        wr(3'd2, 32'h3);
        for (int i = 0; i < 30 && !seen; i++) begin
            @(negedge clk);
            rd(3'd3, s);
            if (s[0]) begin
                seen = 1;
                rd(3'd0, c);
                chk("R5 flag rises the cycle after count==compare", c, 32'd106);
                chk("R8 irq low with interrupt enable off", {31'd0, irq}, 32'h0);
            end
        end
        chk("R5 flag observed", {31'd0, seen}, 32'h1);
    endtask

    task automatic t_sticky;
        logic [31:0] s, c;
        repeat (10) @(negedge clk);
        rd(3'd3, s);
        chk("R6 flag still set after passing compare", s, 32'h1);
        rd(3'd4, c);
        chk("R9 compare unchanged with auto-reload off", c, 32'd105);
        wr(3'd3, 32'h0);
        rd(3'd3, s);
        chk("R6 writing 0 leaves flag", s, 32'h1);
        wr(3'd3, 32'h1);
        rd(3'd3, s);
        chk("R6 writing 1 clears flag", s, 32'h0);
    endtask

    task automatic t_no_cmp;
        logic [31:0] s;
        load_cnt(32'h0, 32'd200);
        wr(3'd4, 32'd205);
        wr(3'd3, 32'h1);
        wr(3'd2, 32'h1);
        repeat (20) @(negedge clk);
        rd(3'd3, s);
        chk("R5 no flag with compare disabled", s, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] s;
        load_cnt(32'h0, 32'd50);
        wr(3'd4, 32'd50);
        wr(3'd2, 32'h2);
        @(negedge clk);
        wr(3'd3, 32'h1);
        rd(3'd3, s);
        chk("R7 clear during match keeps flag", s, 32'h1);
        chk("R8 irq low while disabled", {31'd0, irq}, 32'h0);
        wr(3'd2, 32'h6);
        chk("R8 irq high with flag and enable", {31'd0, irq}, 32'h1);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h1);
        rd(3'd3, s);
        chk("R6 clear once match gone", s, 32'h0);
        chk("R8 irq low after clear", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_auto;
        logic [31:0] s, c, m;
        bit seen;
        load_cnt(32'h0, 32'd0);
        wr(3'd4, 32'd20);
        wr(3'd6, 32'd7);
        wr(3'd3, 32'h1);
        wr(3'd2, 32'hB);
        for (int k = 0; k < 2; k++) begin
            seen = 0;
            for (int i = 0; i < 40 && !seen; i++) begin
                @(negedge clk);
                rd(3'd3, s);
                if (s[0]) begin
                    seen = 1;
                    rd(3'd0, c);
                    rd(3'd4, m);
                    chk("R9 match count", c, 32'd21 + 32'(7 * k));
                    chk("R9 compare advanced by step", m, 32'd27 + 32'(7 * k));
                end
            end
            chk("R9 periodic flag observed", {31'd0, seen}, 32'h1);
            wr(3'd3, 32'h1);
        end
        wr(3'd2, 32'h0);
    endtask

    task automatic t_read_side;
        logic [31:0] v;
        load_cnt(32'h3, 32'hFFFF_FFF0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rd(3'd0, v);
        end
        rd(3'd1, v);
        chk("R10 low reads leave high word", v, 32'h3);
        rd(3'd0, v);
        chk("R10 low word unchanged by reads", v, 32'hFFFF_FFF0);
    endtask

    task automatic t_ctrl;
        logic [31:0] v;
        wr(3'd2, 32'hFFFF_FFF4);
        rd(3'd2, v);
        chk("R11 control keeps only bits 3..0", v, 32'h4);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'hFFFF_FFFE);
        rd(3'd3, v);
        chk("R11 status upper bits zero", v, 32'h0);
        rd(3'd7, v);
        chk("R11 unused address reads zero", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count();
        t_wrap();
        t_wr_guard();
        t_match();
        t_sticky();
        t_no_cmp();
        t_collide();
        t_auto();
        t_read_side();
        t_ctrl();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule